// File: doc/BRIEF.md
# Synchronous burst SRAM cycle controller

This block is the control front end of a single-port synchronous burst memory, with a small behavioural storage array behind it. On every rising clock it samples three chip enables, two address strobes (one for a processor, one for a cache controller), an advance input, a global write, a byte-write enable, per-lane write enables and a sleep input. From these it classifies the cycle as deselect, sleep, begin burst, continue burst or suspend burst, and as a read or a write.

A two-bit burst counter steps through a group of four words, in linear or interleaved order. Writes are masked per byte lane. Read data is registered once and driven under an output enable that acts asynchronously. The three-state bus is modelled as a data output plus a drive-enable output.

A write can only start through the controller strobe or on a later no-strobe cycle. The processor strobe always starts a read. Any cycle with no effective strobe continues or suspends the burst, whatever the chip enables are.

Top module: `sbsram_ctrl`

## Requirements
- R1: The effective write is active when `gw_n` is 0, or when `bw_n` is 0 and at least one bit of `lane_n` is 0. With `gw_n` and `bw_n` at 1, or with `bw_n` at 0 and all `lane_n` bits at 1 (and `gw_n` at 1), the cycle is a read.
- R2: The block is selected only when `cs0_n`=0, `cs1`=1 and `cs2_n`=0. A begin request, through either strobe, while not selected is a deselect cycle: no write, burst state unchanged, `dout_en` low after that edge.
- R3: With `cs0_n`=1 the processor strobe is ignored. If `ctrl_stb_n` is also 1 the cycle continues or suspends the burst. If `ctrl_stb_n` is 0 it is a deselect.
- R4: `proc_stb_n`=0 with the block selected begins a read burst at `addr`, whatever `gw_n`, `bw_n` and `lane_n` are.
- R5: `ctrl_stb_n`=0 with the processor strobe not effective and the block selected begins a burst at `addr`. The burst is a write if the effective write is active, otherwise a read.
- R6: In a cycle with no effective strobe, `adv_n`=0 steps to the next burst address and `adv_n`=1 keeps the current one. The cycle reads or writes according to the effective write.
- R7: The burst offset is 2 bits and wraps within a group of four, with the upper address bits held. Step n from start offset s is at offset (s+n) mod 4 when INTERLEAVE=0, and at offset s xor n when INTERLEAVE=1.
- R8: `sleep`=1 ignores all other controls: no write, no address change, and `dout_en` is low after that edge.
- R9: `dout_en` equals the registered read flag ANDed with `oe_n`=0. It follows `oe_n` without waiting for a clock and is never high after a write, deselect or sleep cycle.
- R10: On a write, lane i (bits 8i+7..8i) is written when `gw_n`=0, or when `bw_n`=0 and `lane_n[i]`=0. All other lanes keep their contents.
- R11: The data of a read cycle sampled at edge k is on `dout` from just after edge k until edge k+1.
- R12: Synchronous reset clears the read flag, so `dout_en` is 0, and clears the burst state to address 0 with offset count 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cs0_n | input | 1 | Chip enable, active low; also gates the processor strobe |
| cs1 | input | 1 | Chip enable, active high |
| cs2_n | input | 1 | Chip enable, active low |
| proc_stb_n | input | 1 | Processor address strobe, active low (read only) |
| ctrl_stb_n | input | 1 | Controller address strobe, active low |
| adv_n | input | 1 | Burst advance, active low |
| gw_n | input | 1 | Global write, all lanes, active low |
| bw_n | input | 1 | Byte-write enable, active low |
| lane_n | input | LANES (4) | Per-lane write enables, active low |
| sleep | input | 1 | Power-down request, active high |
| oe_n | input | 1 | Asynchronous output enable, active low |
| addr | input | ADDR_W (8) | External word address |
| wdata | input | LANES*LANE_W (32) | Write data, sampled on the write edge |
| dout | output | LANES*LANE_W (32) | Registered read data |
| dout_en | output | 1 | Bus drive enable; 0 models a three-stated bus |

## Verification
The hardest condition to reach from the ports is a burst that changes character partway through. For example, a read burst is begun by the processor strobe, then turned into writes by no-strobe cycles, suspended, and later interrupted by deselect or sleep cycles while the counter must hold. The stimulus first fills the whole array with write bursts. Random cycles then have their strobes, enables and sleep biased so that these mixed sequences happen often. Two instances, one per burst order, run side by side, and each read is compared with a reference model that tracks base, count and contents per order.

// File: rtl/sbsram_pkg.sv
package sbsram_pkg;

    localparam int BURST_BITS = 2;

    typedef enum logic [2:0] {
        K_DESEL = 3'd0,
        K_SLEEP = 3'd1,
        K_BEGIN = 3'd2,
        K_CONT  = 3'd3,
        K_SUSP  = 3'd4
    } kind_e;

    typedef struct packed {
        kind_e kind;
        logic  wr;
    } cyc_t;

    // offset of step n in a burst that started at offset s
    function automatic logic [BURST_BITS-1:0] burst_off(
        input logic [BURST_BITS-1:0] s,
        input logic [BURST_BITS-1:0] n,
        input logic                  ilv
    );
        return ilv ? (s ^ n) : (s + n);
    endfunction

    function automatic logic is_access(input kind_e k);
        return (k == K_BEGIN) || (k == K_CONT) || (k == K_SUSP);
    endfunction

endpackage

// File: rtl/sbsram_decode.sv
module sbsram_decode
    import sbsram_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             cs0_n,
    input  logic             cs1,
    input  logic             cs2_n,
    input  logic             proc_stb_n,
    input  logic             ctrl_stb_n,
    input  logic             adv_n,
    input  logic             gw_n,
    input  logic             bw_n,
    input  logic [LANES-1:0] lane_n,
    input  logic             sleep,
    output cyc_t             cyc,
    output logic [LANES-1:0] lane_mask
);
    logic sel, wr_eff, proc_eff;

    always_comb begin
        sel      = !cs0_n && cs1 && !cs2_n;
        wr_eff   = !gw_n || (!bw_n && !(&lane_n));
        proc_eff = !proc_stb_n && !cs0_n;
        cyc.kind = K_DESEL;
        cyc.wr   = 1'b0;
        if (sleep) begin
            cyc.kind = K_SLEEP;
        end else if (proc_eff) begin
            if (sel) cyc.kind = K_BEGIN;   // always a read
        end else if (!ctrl_stb_n) begin
            if (sel) begin
                cyc.kind = K_BEGIN;
                cyc.wr   = wr_eff;
            end
        end else begin
            cyc.kind = adv_n ? K_SUSP : K_CONT;
            cyc.wr   = wr_eff;
        end
        lane_mask = !gw_n ? {LANES{1'b1}} : (!bw_n ? ~lane_n : '0);
    end

endmodule

// File: rtl/sbsram_burst.sv
module sbsram_burst
    import sbsram_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter bit INTERLEAVE = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  kind_e             kind,
    input  logic [ADDR_W-1:0] addr,
    output logic [ADDR_W-1:0] acc_addr
);
    logic [ADDR_W-1:0]     base_q;
    logic [BURST_BITS-1:0] cnt_q, cnt_nx;

    always_comb begin
        cnt_nx   = cnt_q + 1'b1;
        acc_addr = {base_q[ADDR_W-1:BURST_BITS],
                    burst_off(base_q[BURST_BITS-1:0], cnt_q, INTERLEAVE)};
        case (kind)
            K_BEGIN: acc_addr = addr;
            K_CONT:  acc_addr = {base_q[ADDR_W-1:BURST_BITS],
                                 burst_off(base_q[BURST_BITS-1:0], cnt_nx, INTERLEAVE)};
            default: ;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_q <= '0;
            cnt_q  <= '0;
        end else if (kind == K_BEGIN) begin
            base_q <= addr;
            cnt_q  <= '0;
        end else if (kind == K_CONT) begin
            cnt_q  <= cnt_nx;
        end
    end

endmodule

// File: rtl/sbsram_array.sv
module sbsram_array #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    we,
    input  logic                    re,
    input  logic [LANES-1:0]        lane_mask,
    input  logic [ADDR_W-1:0]       a,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rdata_q
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [LANE_W-1:0] mem [DEPTH][LANES];

    for (genvar i = 0; i < LANES; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (we && lane_mask[i]) mem[a][i] <= wdata[i*LANE_W +: LANE_W];
            if (re) rdata_q[i*LANE_W +: LANE_W] <= mem[a][i];
        end
    end

endmodule

// File: rtl/sbsram_ctrl.sv
module sbsram_ctrl
    import sbsram_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int LANES      = 4,
    parameter int LANE_W     = 8,
    parameter bit INTERLEAVE = 1'b0
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cs0_n,
    input  logic                    cs1,
    input  logic                    cs2_n,
    input  logic                    proc_stb_n,
    input  logic                    ctrl_stb_n,
    input  logic                    adv_n,
    input  logic                    gw_n,
    input  logic                    bw_n,
    input  logic [LANES-1:0]        lane_n,
    input  logic                    sleep,
    input  logic                    oe_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] dout,
    output logic                    dout_en
);
    cyc_t              cyc;
    logic [LANES-1:0]  lane_mask;
    logic [ADDR_W-1:0] acc_addr;
    logic              do_wr, do_rd, rd_q;

    sbsram_decode #(.LANES(LANES)) u_dec (
        .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n),
        .proc_stb_n(proc_stb_n), .ctrl_stb_n(ctrl_stb_n), .adv_n(adv_n),
        .gw_n(gw_n), .bw_n(bw_n), .lane_n(lane_n), .sleep(sleep),
        .cyc(cyc), .lane_mask(lane_mask)
    );

    sbsram_burst #(.ADDR_W(ADDR_W), .INTERLEAVE(INTERLEAVE)) u_burst (
        .clk(clk), .rst(rst), .kind(cyc.kind), .addr(addr), .acc_addr(acc_addr)
    );

    assign do_wr = is_access(cyc.kind) && cyc.wr;
    assign do_rd = is_access(cyc.kind) && !cyc.wr;

    sbsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_mem (
        .clk(clk), .we(do_wr && !rst), .re(do_rd), .lane_mask(lane_mask),
        .a(acc_addr), .wdata(wdata), .rdata_q(dout)
    );

    always_ff @(posedge clk) begin
        if (rst) rd_q <= 1'b0;
        else     rd_q <= do_rd;
    end

    // output enable is not sampled: it gates the registered read flag directly
    assign dout_en = rd_q && !oe_n;

endmodule

// File: rtl/sbsram_chk.sv
module sbsram_chk #(
    parameter int ADDR_W = 8,
    parameter int LANES  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              cs0_n,
    input logic              cs1,
    input logic              cs2_n,
    input logic              proc_stb_n,
    input logic              ctrl_stb_n,
    input logic              adv_n,
    input logic              gw_n,
    input logic              bw_n,
    input logic [LANES-1:0]  lane_n,
    input logic              sleep,
    input logic              oe_n,
    input logic [ADDR_W-1:0] acc_addr,
    input logic              dout_en
);
    logic armed;
    logic sel, wr_eff, no_stb;

    assign sel    = !cs0_n && cs1 && !cs2_n;
    assign wr_eff = !gw_n || (!bw_n && !(&lane_n));
    assign no_stb = (proc_stb_n || cs0_n) && ctrl_stb_n;

    always_ff @(posedge clk) begin
        if (rst) armed <= 1'b0;
        else     armed <= 1'b1;
    end

    a_r8_sleep_quiet: assert property (@(posedge clk) disable iff (rst)
        sleep |=> !dout_en);

    a_r2_desel_quiet: assert property (@(posedge clk) disable iff (rst)
        (!sleep && !ctrl_stb_n && !sel && (proc_stb_n || cs0_n)) |=> !dout_en);

    a_r4_proc_forces_read: assert property (@(posedge clk) disable iff (rst)
        (!sleep && !proc_stb_n && sel) |=> (dout_en == !oe_n));

    a_r9_write_masks_oe: assert property (@(posedge clk) disable iff (rst)
        (!sleep && wr_eff && ((no_stb) || (!ctrl_stb_n && sel && (proc_stb_n || cs0_n))))
        |=> !dout_en);

    a_r6_suspend_holds: assert property (@(posedge clk) disable iff (rst)
        (armed && !sleep && no_stb && adv_n) |-> (acc_addr == $past(acc_addr)));

endmodule

bind sbsram_ctrl sbsram_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
    .clk(clk), .rst(rst), .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n),
    .proc_stb_n(proc_stb_n), .ctrl_stb_n(ctrl_stb_n), .adv_n(adv_n),
    .gw_n(gw_n), .bw_n(bw_n), .lane_n(lane_n), .sleep(sleep), .oe_n(oe_n),
    .acc_addr(acc_addr), .dout_en(dout_en)
);

// File: tb/sim_sbsram_ctrl.sv
module sim_sbsram_ctrl;
    localparam int AW = 8;
    localparam int NL = 4;
    localparam int LW = 8;
    localparam int DW = NL * LW;
    localparam int DEPTH = 1 << AW;

    logic clk = 1'b0, rst = 1'b1;
    logic cs0_n = 1, cs1 = 0, cs2_n = 1, proc_stb_n = 1, ctrl_stb_n = 1, adv_n = 1;
    logic gw_n = 1, bw_n = 1, sleep = 0, oe_n = 0;
    logic [NL-1:0] lane_n = '1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] dout0, dout1;
    logic          en0, en1;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    logic [DW-1:0] refm   [2][DEPTH];
    logic [AW-1:0] base_m [2];
    logic [1:0]    cnt_m  [2];
    logic          exp_rd [2];
    logic [DW-1:0] exp_dat[2];
    string         cur_tag;

    always #10 clk = ~clk;   // 50 MHz

    sbsram_ctrl #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW), .INTERLEAVE(1'b0)) u0 (
        .clk(clk), .rst(rst), .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n),
        .proc_stb_n(proc_stb_n), .ctrl_stb_n(ctrl_stb_n), .adv_n(adv_n),
        .gw_n(gw_n), .bw_n(bw_n), .lane_n(lane_n), .sleep(sleep), .oe_n(oe_n),
        .addr(addr), .wdata(wdata), .dout(dout0), .dout_en(en0));

    sbsram_ctrl #(.ADDR_W(AW), .LANES(NL), .LANE_W(LW), .INTERLEAVE(1'b1)) u1 (
        .clk(clk), .rst(rst), .cs0_n(cs0_n), .cs1(cs1), .cs2_n(cs2_n),
        .proc_stb_n(proc_stb_n), .ctrl_stb_n(ctrl_stb_n), .adv_n(adv_n),
        .gw_n(gw_n), .bw_n(bw_n), .lane_n(lane_n), .sleep(sleep), .oe_n(oe_n),
        .addr(addr), .wdata(wdata), .dout(dout1), .dout_en(en1));

    task automatic check(input bit ok, input string tag, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // reference model of one cycle for burst order m (0 linear, 1 interleaved)
    task automatic model(input int m);
        logic sel, wr_eff, proc_eff, begin_c, cont_c, acc, wr;
        logic [1:0] off;
        logic [AW-1:0] a;
        sel      = !cs0_n && cs1 && !cs2_n;
        wr_eff   = !gw_n || (!bw_n && !(&lane_n));
        proc_eff = !proc_stb_n && !cs0_n;
        begin_c = 0; cont_c = 0; acc = 0; wr = 0;
        if (sleep) cur_tag = "R8";
        else if (proc_eff) begin
            cur_tag = sel ? "R4" : "R2";
            begin_c = sel; acc = sel;
        end else if (!ctrl_stb_n) begin
            cur_tag = sel ? "R5" : (cs0_n ? "R3" : "R2");
            begin_c = sel; acc = sel; wr = sel && wr_eff;
        end else begin
            cur_tag = (!proc_stb_n) ? "R3" : "R6";
            acc = 1; wr = wr_eff; cont_c = !adv_n;
        end
        if (begin_c) begin
            base_m[m] = addr; cnt_m[m] = 0;
        end else if (cont_c) cnt_m[m] = cnt_m[m] + 1;
        off = (m == 1) ? (base_m[m][1:0] ^ cnt_m[m]) : (base_m[m][1:0] + cnt_m[m]);
        a = {base_m[m][AW-1:2], off};
        exp_rd[m] = acc && !wr;
        if (exp_rd[m]) exp_dat[m] = refm[m][a];
        if (acc && wr)
            for (int i = 0; i < NL; i++)
                if (!gw_n || (!bw_n && !lane_n[i]))
                    refm[m][a][i*LW +: LW] = wdata[i*LW +: LW];
    endtask

    task automatic step(input string tag_in);
        string t;
        model(0); model(1);
        t = (tag_in == "") ? cur_tag : tag_in;
        @(posedge clk); #2;
        check(en0 == (exp_rd[0] && !oe_n), {t, " en lin"}, {31'd0, en0}, {31'd0, exp_rd[0] && !oe_n});
        check(en1 == (exp_rd[1] && !oe_n), {t, " en ilv"}, {31'd0, en1}, {31'd0, exp_rd[1] && !oe_n});
        if (exp_rd[0] && !oe_n) check(dout0 === exp_dat[0], {t, " data lin"}, dout0, exp_dat[0]);
        if (exp_rd[1] && !oe_n) check(dout1 === exp_dat[1], {t, " data ilv"}, dout1, exp_dat[1]);
    endtask

    task automatic idle();
        cs0_n = 0; cs1 = 1; cs2_n = 0; proc_stb_n = 1; ctrl_stb_n = 1;
        adv_n = 1; gw_n = 1; bw_n = 1; lane_n = '1; sleep = 0; oe_n = 0;
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] hold;
        void'($urandom(32'h5eed_1234));
        for (int m = 0; m < 2; m++) begin base_m[m] = '0; cnt_m[m] = '0; end
        idle();
        repeat (3) @(posedge clk);
        #2 rst = 0;
        check(en0 == 0 && en1 == 0, "R12 reset enable", {31'd0, en0}, '0);

        // fill the whole array with write bursts (controller begin + 3 steps)
        for (int g = 0; g < DEPTH / 4; g++) begin
            idle(); gw_n = 0; ctrl_stb_n = 0; addr = AW'(g * 4); wdata = $urandom;
            step("R5");
            for (int k = 0; k < 3; k++) begin
                idle(); gw_n = 0; adv_n = 0; wdata = $urandom; step("R6");
            end
        end

        // reset clears burst state: a step after reset lands on address 1
        rst = 1; @(posedge clk); #2 rst = 0;
        for (int m = 0; m < 2; m++) begin base_m[m] = '0; cnt_m[m] = '0; end
        idle(); adv_n = 0; step("R12");

        // R4: processor strobe with every write control active still reads
        idle(); proc_stb_n = 0; gw_n = 0; bw_n = 0; lane_n = '0; addr = 8'h46; step("R4");
        // R7: walk the group of four in both orders, starting mid-group
        for (int k = 0; k < 4; k++) begin idle(); adv_n = 0; step("R7"); end

        // R10: partial lane write then read back
        idle(); ctrl_stb_n = 0; bw_n = 0; lane_n = 4'b1010; addr = 8'h21; wdata = 32'hA5C3_7E19;
        step("R10");
        idle(); proc_stb_n = 0; addr = 8'h21; step("R10");

        // R1: byte-write enable low but no lane selected is a read
        idle(); ctrl_stb_n = 0; bw_n = 0; lane_n = '1; addr = 8'h90; step("R1");
        // R1: byte-write enable high with lanes low is a read
        idle(); ctrl_stb_n = 0; bw_n = 1; lane_n = '0; addr = 8'h91; step("R1");

        // R9 and R11: output enable acts without a clock; data holds to the next edge
        idle(); proc_stb_n = 0; addr = 8'h33; step("R11");
        hold = dout0;
        idle(); sleep = 1;
        oe_n = 1; #1;
        check(en0 == 0, "R9 oe off async", {31'd0, en0}, '0);
        oe_n = 0; #1;
        check(en0 == 1, "R9 oe on async", {31'd0, en0}, 1);
        #12;
        check(dout0 === hold, "R11 data held", dout0, hold);
        step("R8");

        // R3: cs0_n high masks the processor strobe; continue happens
        idle(); proc_stb_n = 0; addr = 8'h77; step("R4");
        idle(); cs0_n = 1; proc_stb_n = 0; adv_n = 0; addr = 8'h10; step("R3");
        idle(); cs0_n = 1; ctrl_stb_n = 0; addr = 8'h10; step("R3");
        // R2: unselected begin is ignored, next suspend reads the held address
        idle(); cs1 = 0; ctrl_stb_n = 0; gw_n = 0; addr = 8'hEE; wdata = '1; step("R2");
        idle(); step("R6");

        // random mix
        for (int n = 0; n < 4000; n++) begin
            idle();
            sleep      = ($urandom % 20) == 0;
            cs0_n      = ($urandom % 8) == 0;
            cs1        = ($urandom % 10) != 0;
            cs2_n      = ($urandom % 10) == 0;
            proc_stb_n = ($urandom % 6) != 0;
            ctrl_stb_n = ($urandom % 6) != 0;
            adv_n      = ($urandom % 3) == 0;
            gw_n       = ($urandom % 6) != 0;
            bw_n       = ($urandom % 3) == 0;
            lane_n     = NL'($urandom);
            oe_n       = ($urandom % 5) == 0;
            addr       = AW'($urandom);
            wdata      = $urandom;
            step("");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule